// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block sits between the analog protection comparators of a step-down regulator and its power switches. It receives digitised threshold flags for output undervoltage, output overvoltage, output above reference, valley overcurrent, peak overcurrent and die temperature. It also receives enable, the supply-good (power-on reset) flag, a startup-ramp-complete flag and a once-per-switching-cycle strobe. Every incoming flag first passes through a two-stage synchroniser.

From these inputs it drives the protective overrides. These are the permissions for high-side and low-side switching, a forced low-side pulldown used as a soft crowbar during overvoltage, a soft-discharge enable and the power-good output. A fault latches and stays latched until the supply-good flag drops or enable is taken low. A thermal fault also needs the die to have cooled below its recovery point before it clears. A cause register keeps the code of the first fault that latched since the last clear.

Top module: `pfs_supervisor`

## Requirements
- R1: With the ramp complete and the part running, an undervoltage flag latches a fault. The fault clears hs_en, ls_en and pgood, sets dis_en and records cause code 1.
- R2: An undervoltage flag has no effect while ss_done is low. Switching stays permitted and fault_cause stays 0.
- R3: An overvoltage flag latches a fault with cause code 2. The fault clears hs_en, ls_en and pgood and does not by itself set dis_en.
- R4: While the overvoltage fault is latched, ls_force follows above_ref: high when the output is above the reference and low when it is below.
- R5: A valley overcurrent flag sampled high on 8 consecutive cycle strobes latches a fault with cause code 3, switches off and dis_en high. A strobe with the flag low restarts the count.
- R6: A peak overcurrent flag latches a fault at once, with cause code 4, switches off, dis_en high and pgood low.
- R7: An over-temperature flag latches a fault with cause code 5 and switches off. The fault clears only when enable is low or supply-good is low while the cool flag is high.
- R8: Undervoltage, overvoltage and overcurrent faults stay latched after their flags drop. They clear when en or por_ok goes low.
- R9: With en or por_ok low, dis_en is high and hs_en, ls_en and pgood are low.
- R10: pgood is high only when por_ok, en and ss_done are high and no fault is latched.
- R11: fault_cause keeps the first fault since the last clear. Later faults do not change it. When several faults arrive in the same cycle, the order is peak, then overvoltage, then undervoltage, then valley, then thermal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Supplies above power-on reset level |
| en | input | 1 | Regulation enable |
| ss_done | input | 1 | Startup ramp has reached its target |
| uv_flag | input | 1 | Output below 84 % of reference |
| ov_flag | input | 1 | Output above 116 % of reference |
| above_ref | input | 1 | Output above reference |
| valley_oc | input | 1 | Valley current above limit |
| cyc_stb | input | 1 | Once-per-switching-cycle strobe |
| peak_oc | input | 1 | High-side peak current above limit |
| ot_hot | input | 1 | Die above shutdown temperature |
| ot_cool | input | 1 | Die below recovery temperature |
| hs_en | output | 1 | High-side switching permitted |
| ls_en | output | 1 | Low-side switching permitted |
| ls_force | output | 1 | Low side forced on for overvoltage pulldown |
| dis_en | output | 1 | Soft-discharge enable |
| pgood | output | 1 | Power-good |
| fault_cause | output | 3 | First-fault code (0 none, 1 UV, 2 OV, 3 valley, 4 peak, 5 thermal) |

## Verification
The fault path is exercised with single faults, a second fault arriving on top of a latched one, and several faults in the same cycle. These three patterns separate latching, first-cause retention and priority. Clear sequences cover an enable pulse, a supply-good drop, and a thermal clear tried both hot and cool, which tells apart a plain latch from the cooling condition. Valley qualification is fed seven over-limit strobes, one clean strobe, seven more and then one final strobe. This shows that the count restarts and does not accumulate.

// File: rtl/pfs_pkg.sv
// Shared definitions for the power stage fault supervisor.
// Assumes fault codes are consumed as a 3-bit field.
package pfs_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_UNDER   = 3'd1,
        CAUSE_OVER    = 3'd2,
        CAUSE_VALLEY  = 3'd3,
        CAUSE_PEAK    = 3'd4,
        CAUSE_THERMAL = 3'd5
    } fault_cause_e;

    // Bit positions of the synchronised flag bundle
    localparam int FL_POR   = 0;
    localparam int FL_EN    = 1;
    localparam int FL_SS    = 2;
    localparam int FL_UV    = 3;
    localparam int FL_OV    = 4;
    localparam int FL_ABV   = 5;
    localparam int FL_VOC   = 6;
    localparam int FL_STB   = 7;
    localparam int FL_PK    = 8;
    localparam int FL_HOT   = 9;
    localparam int FL_COOL  = 10;
    localparam int FL_COUNT = 11;
endpackage

// File: rtl/pfs_sync.sv
// Multi-stage flag synchroniser, one chain per bit.
// Assumes inputs are quasi-static levels relative to clk; the reset value is 0.
module pfs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift each flag through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_valley_qual.sv
// Consecutive-cycle valley overcurrent qualifier.
// Assumes stb is a synchronised level strobe; a rising edge marks one switching cycle.
// Emits a one-clock trip when the over flag is high on CYCLES consecutive strobes.
module pfs_valley_qual #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic over,
    output logic trip
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic          stb_q;
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = stb & ~stb_q;
    assign trip = tick & over & (cnt == LAST);

    // Remember the strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    // Count consecutive over-limit cycles, restarting on a clean cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (tick) begin
            if (!over)           cnt <= '0;
            else if (cnt != LAST) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_cause_reg.sv
// First-fault cause register with fixed priority for same-cycle faults.
// Assumes set bits are single-cycle qualified fault events; clear wins over set.
module pfs_cause_reg
    import pfs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         keep_thermal,
    input  logic         set_pk,
    input  logic         set_ov,
    input  logic         set_uv,
    input  logic         set_voc,
    input  logic         set_ot,
    output fault_cause_e cause
);
    fault_cause_e first;

    // Select the highest-priority new event
    always_comb begin
        if (set_pk)       first = CAUSE_PEAK;
        else if (set_ov)  first = CAUSE_OVER;
        else if (set_uv)  first = CAUSE_UNDER;
        else if (set_voc) first = CAUSE_VALLEY;
        else if (set_ot)  first = CAUSE_THERMAL;
        else              first = CAUSE_NONE;
    end

    // Hold the first cause until cleared; a surviving thermal latch keeps its code
    always_ff @(posedge clk) begin
        if (!rst_n)                  cause <= CAUSE_NONE;
        else if (clr)                cause <= keep_thermal ? CAUSE_THERMAL : CAUSE_NONE;
        else if (cause == CAUSE_NONE) cause <= first;
    end
endmodule

// File: rtl/pfs_supervisor.sv
// Power stage fault supervisor top.
// Synchronises the comparator flags, latches protection faults and drives the
// switch overrides, soft-discharge, overvoltage pulldown and power-good.
// Assumes flags are active-high levels and cyc_stb is high for at least one clk per cycle.
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int VALLEY_COUNT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       en,
    input  logic       ss_done,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       above_ref,
    input  logic       valley_oc,
    input  logic       cyc_stb,
    input  logic       peak_oc,
    input  logic       ot_hot,
    input  logic       ot_cool,
    output logic       hs_en,
    output logic       ls_en,
    output logic       ls_force,
    output logic       dis_en,
    output logic       pgood,
    output logic [2:0] fault_cause
);
    logic [FL_COUNT-1:0] raw, s;
    logic run, clr, trip;
    logic set_uv, set_ov, set_pk, set_voc, set_ot;
    logic uv_f, ov_f, voc_f, pk_f, ot_f, ot_n, any_f;
    fault_cause_e cause;

    // Gather raw flags into the bundle
    always_comb begin
        raw          = '0;
        raw[FL_POR]  = por_ok;
        raw[FL_EN]   = en;
        raw[FL_SS]   = ss_done;
        raw[FL_UV]   = uv_flag;
        raw[FL_OV]   = ov_flag;
        raw[FL_ABV]  = above_ref;
        raw[FL_VOC]  = valley_oc;
        raw[FL_STB]  = cyc_stb;
        raw[FL_PK]   = peak_oc;
        raw[FL_HOT]  = ot_hot;
        raw[FL_COOL] = ot_cool;
    end

    pfs_sync #(.W(FL_COUNT), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(s)
    );

    assign run = s[FL_POR] & s[FL_EN];
    assign clr = ~run;

    pfs_valley_qual #(.CYCLES(VALLEY_COUNT)) valley_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .stb(s[FL_STB]), .over(s[FL_VOC]), .trip(trip)
    );

    assign set_uv  = run & s[FL_SS] & s[FL_UV];
    assign set_ov  = run & s[FL_OV];
    assign set_pk  = run & s[FL_PK];
    assign set_voc = run & trip;
    assign set_ot  = run & s[FL_HOT];
    assign ot_n    = (ot_f | s[FL_HOT]) & ~(clr & s[FL_COOL]);

    // Latch electrical faults until an enable or supply-good drop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            uv_f  <= 1'b0;
            ov_f  <= 1'b0;
            voc_f <= 1'b0;
            pk_f  <= 1'b0;
        end else begin
            uv_f  <= uv_f  | set_uv;
            ov_f  <= ov_f  | set_ov;
            voc_f <= voc_f | set_voc;
            pk_f  <= pk_f  | set_pk;
        end
    end

    // Latch thermal fault; clearing also needs the die to be cool
    always_ff @(posedge clk) begin
        if (!rst_n) ot_f <= 1'b0;
        else        ot_f <= ot_n;
    end

    pfs_cause_reg cause_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .keep_thermal(ot_n),
        .set_pk(set_pk), .set_ov(set_ov), .set_uv(set_uv),
        .set_voc(set_voc), .set_ot(set_ot), .cause(cause)
    );

    assign any_f       = uv_f | ov_f | voc_f | pk_f | ot_f;
    assign hs_en       = run & ~any_f;
    assign ls_en       = run & ~any_f;
    assign ls_force    = ov_f & s[FL_ABV];
    assign dis_en      = clr | uv_f | voc_f | pk_f;
    assign pgood       = run & ~any_f & s[FL_SS];
    assign fault_cause = cause;
endmodule

// File: rtl/pfs_supervisor_chk.sv
// Port-level property checker for pfs_supervisor, attached by bind.
// Assumes the default two-stage synchroniser depth.
module pfs_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_ok,
    input logic       en,
    input logic       ss_done,
    input logic       above_ref,
    input logic       hs_en,
    input logic       ls_en,
    input logic       ls_force,
    input logic       dis_en,
    input logic       pgood,
    input logic [2:0] fault_cause
);
    a_r1_fault_blocks_switching: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cause != 3'd0) |-> (!hs_en && !ls_en && !pgood));

    a_r4_force_tracks_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force |-> $past(above_ref, 2));

    a_r4_force_excludes_switching: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force |-> (!hs_en && !ls_en));

    a_r9_disable_discharges: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en, 2) || !$past(por_ok, 2)) |-> (dis_en && !pgood && !hs_en));

    a_r10_pgood_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> ($past(ss_done, 2) && $past(en, 2) && $past(por_ok, 2) && fault_cause == 3'd0));

    a_r11_cause_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_cause) != 3'd0 && fault_cause != $past(fault_cause))
            |-> (fault_cause == 3'd0 || fault_cause == 3'd5));
endmodule

bind pfs_supervisor pfs_supervisor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .ss_done(ss_done),
    .above_ref(above_ref), .hs_en(hs_en), .ls_en(ls_en), .ls_force(ls_force),
    .dis_en(dis_en), .pgood(pgood), .fault_cause(fault_cause)
);

// File: tb/pfs_supervisor_tb_top.sv
// Vector-table bench for pfs_supervisor plus directed reset and valley tests.
module pfs_supervisor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok = 0, en = 0, ss_done = 0, uv_flag = 0, ov_flag = 0, above_ref = 0;
    logic valley_oc = 0, cyc_stb = 0, peak_oc = 0, ot_hot = 0, ot_cool = 1;
    logic hs_en, ls_en, ls_force, dis_en, pgood;
    logic [2:0] fault_cause;
    int applied = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    pfs_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .ss_done(ss_done),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .above_ref(above_ref),
        .valley_oc(valley_oc), .cyc_stb(cyc_stb), .peak_oc(peak_oc),
        .ot_hot(ot_hot), .ot_cool(ot_cool), .hs_en(hs_en), .ls_en(ls_en),
        .ls_force(ls_force), .dis_en(dis_en), .pgood(pgood), .fault_cause(fault_cause)
    );

    // inputs: por en ss uv ov abv pk hot cool | expected: hs ls frc dis pg | cause
    localparam int NV = 26;
    localparam logic [16:0] VEC [NV] = '{
        {9'b000000001, 5'b00010, 3'd0},  // R9 supply-good low
        {9'b100000001, 5'b00010, 3'd0},  // R9 enable low
        {9'b110000001, 5'b11000, 3'd0},  // R10 ramp not done
        {9'b110100001, 5'b11000, 3'd0},  // R2 uv masked
        {9'b111000001, 5'b11001, 3'd0},  // R10 power good
        {9'b111100001, 5'b00010, 3'd1},  // R1 undervoltage
        {9'b111000001, 5'b00010, 3'd1},  // R8 persists
        {9'b101000001, 5'b00010, 3'd0},  // R8 enable clear
        {9'b111000001, 5'b11001, 3'd0},  // R10
        {9'b111011001, 5'b00100, 3'd2},  // R3 R4 overvoltage above ref
        {9'b111000001, 5'b00000, 3'd2},  // R4 below ref
        {9'b111101001, 5'b00110, 3'd2},  // R11 second fault keeps cause
        {9'b011000001, 5'b00010, 3'd0},  // R8 supply-good clear
        {9'b111000001, 5'b11001, 3'd0},
        {9'b111000101, 5'b00010, 3'd4},  // R6 peak overcurrent
        {9'b101000001, 5'b00010, 3'd0},
        {9'b111000010, 5'b00000, 3'd5},  // R7 thermal
        {9'b101000010, 5'b00010, 3'd5},  // R7 enable low while hot
        {9'b111000000, 5'b00000, 3'd5},  // R7 not yet cool
        {9'b111000001, 5'b00000, 3'd5},  // R7 cool without enable cycle
        {9'b101000001, 5'b00010, 3'd0},  // R7 cool clear
        {9'b111000001, 5'b11001, 3'd0},
        {9'b111110101, 5'b00010, 3'd4},  // R11 peak wins
        {9'b101000001, 5'b00010, 3'd0},
        {9'b111110001, 5'b00010, 3'd2},  // R11 ov beats uv
        {9'b101000001, 5'b00010, 3'd0}
    };

    function automatic logic [7:0] outs();
        return {hs_en, ls_en, ls_force, dis_en, pgood, fault_cause};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_stb(input logic over);
        valley_oc = over;
        @(negedge clk); cyc_stb = 1'b1;
        @(negedge clk); cyc_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state: discharge on, all else off
        check("R9 reset", outs(), 8'b00010_000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {por_ok, en, ss_done, uv_flag, ov_flag, above_ref, peak_oc, ot_hot, ot_cool} = VEC[i][16:8];
            repeat (6) @(negedge clk);
            check($sformatf("vector %0d", i), outs(), VEC[i][7:0]);
        end
        // R5 valley qualification with a restart in the middle
        {por_ok, en, ss_done, uv_flag, ov_flag, above_ref, peak_oc, ot_hot, ot_cool} = 9'b111000001;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 7; k++) pulse_stb(1'b1);
        pulse_stb(1'b0);
        for (int k = 0; k < 7; k++) pulse_stb(1'b1);
        repeat (4) @(negedge clk);
        check("R5 count restarted", outs(), 8'b11001_000);
        pulse_stb(1'b1);
        repeat (4) @(negedge clk);
        check("R5 valley trip", outs(), 8'b00010_011);
        valley_oc = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 valley persists", outs(), 8'b00010_011);
        en = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 valley cleared", outs(), 8'b00010_000);
        // R9 reset during run returns to reset state
        en = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset mid-run", outs(), 8'b00010_000);
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule